// File: doc/BRIEF.md
# ATA Programmed-I/O Access Sequencer

This block carries out one programmed-I/O register access on an ATA/ATAPI device bus for each request from a host-side requester. The requester presents a 4-bit register address, a 16-bit write word and a write flag, and holds them with `req_valid` until the block answers with a one-cycle `ack`. The block then drives the device address and chip-select lines and runs the read or write strobe through four phases. Each phase length is programmable at run time: address setup, strobe active, write-data hold and end-of-cycle recovery.

A phase programmed with value N lasts N+1 clock cycles. At a 100 MHz clock, suitable PIO mode 0 values are setup 6, active 28, hold 2 and recovery 23. The recovery value covers the rest of the 600 ns minimum cycle after setup and strobe width. When the ready-wait enable is set, a device holding IORDY low stretches the strobe-active phase; the line passes through a two-flop synchronizer first. Read data is taken from the device bus on the edge that releases the read strobe. A controller-enable input turns the whole bus side quiet. A reset-control input drives the device reset line.

Top module: `ata_pio_seq`

## Requirements
- R1: Address bit 3 picks the chip select: 1 drives `cs1_n` low and 0 drives `cs0_n` low, never both together. `da` carries address bits 2..0 while a select is low.
- R2: Call the edge that takes the request the accept edge. Chip select, `da` and (for a write) `dd_oe` take effect at the accept edge. The strobe (`rd_n` for a read, `wr_n` for a write) goes low at edge accept+t_setup+1. Without a ready wait it goes high t_active+1 edges after that. `ack` rises t_hold+1 edges after the strobe rises.
- R3: On a read, `rdata` takes the value of `dd_in` sampled at the edge that raises `rd_n`. A write leaves `rdata` unchanged.
- R4: For a write, `dd_out` equals `req_wdata` and `dd_oe` is high from the accept edge until the edge that raises `ack`. `dd_oe` is never high during a read.
- R5: With `iordy_en`=1, the strobe rises at the later of two edges: the end of the active count, and the third edge after `iordy` is first sampled high (two synchronizer flops, then the sequencer).
- R6: With `iordy_en`=0, the level of `iordy` has no effect on strobe timing.
- R7: `ack` is high for exactly one cycle per request. Both chip selects are high whenever `ack` is high.
- R8: After the edge that raises `ack`, a pending request is accepted at the (t_recover+1)-th edge and no earlier.
- R9: While `ctl_enable`=0, a request is acknowledged one edge after it is taken, with no chip select, strobe or `dd_oe` activity.
- R10: `dev_rst_n` equals the inverse of `ctl_dev_reset`, registered one edge later; it is low while `rst_n` is low.
- R11: During reset, both chip selects and both strobes are high, and `dd_oe` and `ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_enable | input | 1 | Bus side enable; 0 keeps the device bus quiet |
| ctl_dev_reset | input | 1 | 1 asserts the device reset line |
| t_setup | input | 8 | Address-to-strobe phase value |
| t_active | input | 8 | Strobe-low phase value |
| t_hold | input | 8 | Post-strobe hold phase value |
| t_recover | input | 8 | End-of-cycle recovery phase value |
| iordy_en | input | 1 | Lets IORDY stretch the active phase |
| req_valid | input | 1 | Request present, held until ack |
| req_addr | input | 4 | Bit 3 selects chip select, bits 2..0 register address |
| req_wdata | input | 16 | Data to write |
| req_write | input | 1 | 1 write, 0 read |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| dev_rst_n | output | 1 | Device reset, active low |
| dd_in | input | 16 | Device data bus input |
| dd_out | output | 16 | Device data bus output |
| dd_oe | output | 1 | Data bus output enable |
| da | output | 3 | Device register address |
| cs0_n | output | 1 | Command-block select, active low |
| cs1_n | output | 1 | Control-block select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| iordy | input | 1 | Device ready, asynchronous |

## Verification
The assertions assume the requester behaves in three ways. It holds the request fields stable until `ack`. It drops or replaces the request in the cycle `ack` is seen. It changes `ctl_enable` and the timing values only while no access is in flight. The bench drives every input at the falling clock edge and keeps to these rules. It replaces the request right after `ack` to measure recovery, and it only raises or lowers `iordy` at points where the synchronizer delay can be counted exactly. It sweeps all four phase values over 0..3, in both directions, and with three ready-wait patterns. It also runs one access with the mode 0 values.

// File: rtl/ata_pio_pkg.sv
`timescale 1ns/1ps
package ata_pio_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETUP   = 3'd1,
      ST_ACTIVE  = 3'd2,
      ST_HOLD    = 3'd3,
      ST_RECOVER = 3'd4
   } pio_state_t;
endpackage

// File: rtl/ata_pio_sync.sv
`timescale 1ns/1ps
module ata_pio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("ata_pio_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ata_pio_phase_ctr.sv
`timescale 1ns/1ps
module ata_pio_phase_ctr #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] value,
   output logic          zero
);
   if (TW < 1) begin : g_bad_tw
      $error("ata_pio_phase_ctr: TW must be at least 1");
   end

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= value;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/ata_pio_seq.sv
`timescale 1ns/1ps
module ata_pio_seq #(
   parameter int TW          = 8,
   parameter int AW          = 4,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_enable,
   input  logic            ctl_dev_reset,
   input  logic [TW-1:0]   t_setup,
   input  logic [TW-1:0]   t_active,
   input  logic [TW-1:0]   t_hold,
   input  logic [TW-1:0]   t_recover,
   input  logic            iordy_en,
   input  logic            req_valid,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   input  logic            req_write,
   output logic            ack,
   output logic [DW-1:0]   rdata,
   output logic            dev_rst_n,
   input  logic [DW-1:0]   dd_in,
   output logic [DW-1:0]   dd_out,
   output logic            dd_oe,
   output logic [AW-2:0]   da,
   output logic            cs0_n,
   output logic            cs1_n,
   output logic            rd_n,
   output logic            wr_n,
   input  logic            iordy
);
   import ata_pio_pkg::*;

   localparam int DAW    = AW - 1;
   localparam int SEL_BIT = AW - 1;

   if (AW < 2) begin : g_bad_aw
      $error("ata_pio_seq: AW must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ata_pio_seq: DW must be at least 1");
   end

   pio_state_t    st, st_nx;
   logic          ctr_load;
   logic [TW-1:0] ctr_val;
   logic          ctr_zero;
   logic          rdy_s;
   logic          wr_q;
   logic          strobe_done;
   logic          can_take;

   ata_pio_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (iordy),
      .q     (rdy_s)
   );

   ata_pio_phase_ctr #(.TW(TW)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ctr_load),
      .value (ctr_val),
      .zero  (ctr_zero)
   );

   assign strobe_done = ctr_zero && (!iordy_en || rdy_s);
   assign can_take    = ctr_zero && req_valid &&
                        ((st == ST_IDLE) || (st == ST_RECOVER));

   // next state and phase counter reload
   always_comb begin
      st_nx    = st;
      ctr_load = 1'b0;
      ctr_val  = '0;
      unique case (st)
         ST_IDLE, ST_RECOVER: begin
            if (ctr_zero) begin
               if (req_valid && ctl_enable) begin
                  st_nx    = ST_SETUP;
                  ctr_load = 1'b1;
                  ctr_val  = t_setup;
               end else if (req_valid) begin
                  st_nx    = ST_RECOVER;
                  ctr_load = 1'b1;
                  ctr_val  = '0;
               end else begin
                  st_nx    = ST_IDLE;
               end
            end
         end
         ST_SETUP: begin
            if (ctr_zero) begin
               st_nx    = ST_ACTIVE;
               ctr_load = 1'b1;
               ctr_val  = t_active;
            end
         end
         ST_ACTIVE: begin
            if (strobe_done) begin
               st_nx    = ST_HOLD;
               ctr_load = 1'b1;
               ctr_val  = t_hold;
            end
         end
         ST_HOLD: begin
            if (ctr_zero) begin
               st_nx    = ST_RECOVER;
               ctr_load = 1'b1;
               ctr_val  = t_recover;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   // registered device-bus pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs0_n     <= 1'b1;
         cs1_n     <= 1'b1;
         rd_n      <= 1'b1;
         wr_n      <= 1'b1;
         dd_oe     <= 1'b0;
         dd_out    <= '0;
         da        <= '0;
         ack       <= 1'b0;
         rdata     <= '0;
         wr_q      <= 1'b0;
         dev_rst_n <= 1'b0;
      end else begin
         dev_rst_n <= !ctl_dev_reset;
         ack       <= 1'b0;
         unique case (st)
            ST_IDLE, ST_RECOVER: begin
               if (can_take) begin
                  if (ctl_enable) begin
                     cs1_n  <= !req_addr[SEL_BIT];
                     cs0_n  <=  req_addr[SEL_BIT];
                     da     <= req_addr[DAW-1:0];
                     dd_out <= req_wdata;
                     dd_oe  <= req_write;
                     wr_q   <= req_write;
                  end else begin
                     ack    <= 1'b1;
                  end
               end
            end
            ST_SETUP: begin
               if (ctr_zero) begin
                  rd_n <= wr_q;
                  wr_n <= !wr_q;
               end
            end
            ST_ACTIVE: begin
               if (strobe_done) begin
                  rd_n <= 1'b1;
                  wr_n <= 1'b1;
                  if (!wr_q) rdata <= dd_in;
               end
            end
            ST_HOLD: begin
               if (ctr_zero) begin
                  cs0_n <= 1'b1;
                  cs1_n <= 1'b1;
                  dd_oe <= 1'b0;
                  ack   <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ata_pio_seq_chk.sv
`timescale 1ns/1ps
module ata_pio_seq_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_enable,
   input logic          ctl_dev_reset,
   input logic          ack,
   input logic [DW-1:0] rdata,
   input logic          dev_rst_n,
   input logic [DW-1:0] dd_in,
   input logic          dd_oe,
   input logic          cs0_n,
   input logic          cs1_n,
   input logic          rd_n,
   input logic          wr_n
);
   AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(!cs0_n && !cs1_n)); // R1
   AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R2
   AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> (cs0_n != cs1_n)); // R2
   AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_n) |-> (rdata == $past(dd_in))); // R3
   AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !dd_oe); // R4
   AST_WRITE_HOLD_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_n) |-> dd_oe); // R4
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R7
   AST_ACK_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ack |-> (cs0_n && cs1_n)); // R7
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!ctl_enable && cs0_n && cs1_n) |=> (cs0_n && cs1_n && rd_n && wr_n && !dd_oe)); // R9
   AST_DEVRST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (dev_rst_n == !$past(ctl_dev_reset))); // R10
endmodule

bind ata_pio_seq ata_pio_seq_chk #(.DW(DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_enable    (ctl_enable),
   .ctl_dev_reset (ctl_dev_reset),
   .ack           (ack),
   .rdata         (rdata),
   .dev_rst_n     (dev_rst_n),
   .dd_in         (dd_in),
   .dd_oe         (dd_oe),
   .cs0_n         (cs0_n),
   .cs1_n         (cs1_n),
   .rd_n          (rd_n),
   .wr_n          (wr_n)
);

// File: tb/ata_pio_seq_bench.sv
`timescale 1ns/1ps
module ata_pio_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n, ctl_enable, ctl_dev_reset, iordy_en, iordy;
   logic [7:0]  t_setup, t_active, t_hold, t_recover;
   logic        req_valid, req_write;
   logic [3:0]  req_addr;
   logic [15:0] req_wdata, dd_in;
   logic        ack, dev_rst_n, dd_oe, cs0_n, cs1_n, rd_n, wr_n;
   logic [15:0] rdata, dd_out;
   logic [2:0]  da;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic [15:0] last_rd;

   always #5 clk = ~clk;

   ata_pio_seq u_ata_pio_seq (
      .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_dev_reset(ctl_dev_reset),
      .t_setup(t_setup), .t_active(t_active), .t_hold(t_hold), .t_recover(t_recover),
      .iordy_en(iordy_en), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .ack(ack), .rdata(rdata),
      .dev_rst_n(dev_rst_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
      .da(da), .cs0_n(cs0_n), .cs1_n(cs1_n), .rd_n(rd_n), .wr_n(wr_n), .iordy(iordy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one access; cycle k = state after the k-th rising edge since the request
   task automatic xfer(input int t1, input int t2, input int t4, input int te,
                       input bit we, input logic [3:0] a, input logic [15:0] wd,
                       input bit ien, input int r, input logic [7:0] seq);
      int rs, re, ea, k, j;
      bit ecs, estr;
      string tg;
      rs = t1 + 2;
      re = t1 + t2 + 3;
      if (ien && (r + 3 > re)) re = r + 3;
      ea = re + t4 + 1;
      tg = !ien ? "R6" : ((r > 0) ? "R5" : "R2");
      t_setup = 8'(t1); t_active = 8'(t2); t_hold = 8'(t4); t_recover = 8'(te);
      iordy_en = ien; iordy = (ien && r == 0);
      req_addr = a; req_wdata = wd; req_write = we; req_valid = 1'b1;
      dd_in = {seq, 8'd1};
      k = 0;
      while (k < ea) begin
         @(posedge clk); k++; @(negedge clk);
         ecs  = (k < ea);
         estr = (k >= rs) && (k < re);
         chk({cs1_n, cs0_n} == {!(ecs && a[3]), !(ecs && !a[3])}, "R1 select",
             int'({cs1_n, cs0_n}), int'({!(ecs && a[3]), !(ecs && !a[3])}));
         if (ecs) chk(da == a[2:0], "R1 da", int'(da), int'(a[2:0]));
         chk({rd_n, wr_n} == {!(estr && !we), !(estr && we)}, tg,
             int'({rd_n, wr_n}), int'({!(estr && !we), !(estr && we)}));
         chk(dd_oe == (we && ecs), "R4 oe", int'(dd_oe), int'(we && ecs));
         if (we && ecs) chk(dd_out == wd, "R4 data", int'(dd_out), int'(wd));
         chk(ack == (k == ea), "R7 ack", int'(ack), int'(k == ea));
         if (ien && k == r) iordy = 1'b1;
         dd_in = {seq, 8'(k + 1)};
      end
      if (!we) begin
         chk(rdata == {seq, 8'(re)}, "R3 capture", int'(rdata), int'({seq, 8'(re)}));
         last_rd = {seq, 8'(re)};
      end else begin
         chk(rdata == last_rd, "R3 write keeps", int'(rdata), int'(last_rd));
      end
      // replace the request at once and time the recovery (R8)
      req_write = 1'b0; req_addr = 4'h5; iordy = 1'b1;
      j = 0;
      do begin
         @(posedge clk); j++; @(negedge clk);
      end while (cs0_n && cs1_n && j < 600);
      chk(j == te + 1, "R8 recovery", j, te + 1);
      j = 0;
      while (!ack && j < 600) begin
         @(posedge clk); j++; @(negedge clk);
      end
      req_valid = 1'b0;
      last_rd = dd_in;
      repeat (te + 2) @(negedge clk);
   endtask

   initial begin
      #1500000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ctl_enable = 1'b1; ctl_dev_reset = 1'b0;
      t_setup = 8'd0; t_active = 8'd0; t_hold = 8'd0; t_recover = 8'd0;
      iordy_en = 1'b0; iordy = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = 4'h0; req_wdata = 16'h0; dd_in = 16'h0; last_rd = 16'h0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk({cs0_n, cs1_n, rd_n, wr_n} == 4'hF, "R11 pins", int'({cs0_n, cs1_n, rd_n, wr_n}), 15);
      chk({dd_oe, ack} == 2'b00, "R11 oe/ack", int'({dd_oe, ack}), 0);
      chk(dev_rst_n == 1'b0, "R10 reset low", int'(dev_rst_n), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(dev_rst_n == 1'b1, "R10 released", int'(dev_rst_n), 1);
      ctl_dev_reset = 1'b1;
      @(negedge clk);
      chk(dev_rst_n == 1'b0, "R10 asserted", int'(dev_rst_n), 0);
      ctl_dev_reset = 1'b0;
      @(negedge clk);
      chk(dev_rst_n == 1'b1, "R10 deasserted", int'(dev_rst_n), 1);

      // sweep all phase values 0..3, both directions, three ready-wait patterns
      for (int i = 0; i < 256; i++) begin
         int t1, t2, t4, te, mode, r;
         bit ien;
         t1 = i % 4; t2 = (i / 4) % 4; t4 = (i / 16) % 4; te = i / 64;
         mode = i % 3;
         ien = (mode != 0);
         r = (mode == 0) ? -1 : ((mode == 1) ? 0 : t1 + t2 + 1 + (i % 4));
         xfer(t1, t2, t4, te, i[0], 4'(i * 7), 16'(i * 16'h1357 + 16'h0F0F),
              ien, r, 8'(i));
      end

      // PIO mode 0 values, write then read
      xfer(6, 28, 2, 23, 1'b1, 4'hA, 16'hBEEF, 1'b0, -1, 8'hE1);
      xfer(6, 28, 2, 23, 1'b0, 4'h2, 16'h0000, 1'b1, 0, 8'hE2);

      // R9 controller disabled
      ctl_enable = 1'b0;
      t_setup = 8'd1; t_active = 8'd1; t_hold = 8'd1; t_recover = 8'd0;
      req_addr = 4'hE; req_write = 1'b1; req_wdata = 16'h1234; req_valid = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         @(posedge clk); @(negedge clk);
         chk(ack == (k == 1), "R9 ack", int'(ack), int'(k == 1));
         chk({cs0_n, cs1_n, rd_n, wr_n, dd_oe} == 5'b11110, "R9 quiet",
             int'({cs0_n, cs1_n, rd_n, wr_n, dd_oe}), 30);
         if (k == 1) req_valid = 1'b0;
      end
      ctl_enable = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule